// File: doc/BRIEF.md
# Receive Ring Free-Descriptor Tracker

This block keeps count of the free receive buffer descriptors left in a circular descriptor ring. The receiver consumes descriptors one at a time and signals each use with a single-cycle pulse. Software hands descriptors back by writing a free-descriptor pointer that marks how far the returned region reaches. The block derives the free count by modulo arithmetic between the hardware consume position and the software free pointer. Two equal pointers mean an empty ring.

A narrow write port programs the ring base address, the free pointer, the ring length (in descriptors) and a free threshold. Writing the base rewinds both pointers to it, which empties the ring. When the free count falls below the threshold, a registered flow-control request goes high so that the link layer can throttle the sender. If the receiver tries to consume from an empty ring, the consume position holds and a sticky underrun flag is raised.

Top module: `rx_free_desc_tracker`

## Requirements
- R1: After reset the free count is 0, the empty flag is 1, the flow-control request is 0, the underrun flag is 0 and the consume pointer is 0.
- R2: A write with select 0 (ring base) sets the consume pointer to the base, sets the free pointer to the base and clears the underrun flag. From the next cycle the free count reads 0 and the empty flag reads 1.
- R3: Write selects are 0 = base, 1 = free pointer, 2 = ring length, 3 = threshold. Each descriptor is 8 bytes. The free count is ((free pointer - base)/8 - consume index) modulo ring length, and it is visible in the cycle after the write.
- R4: When the free pointer equals the consume pointer, the free count is 0 and the empty flag is 1.
- R5: Each consume pulse taken with a nonzero count advances the consume pointer by 8 bytes and lowers the count by one. After index length-1 the pointer wraps back to the base.
- R6: A free-pointer write keeps only data bits [27:0]. Bits [31:28] of the stored free pointer are taken from the current consume pointer.
- R7: The flow-control request is high in the cycle after a cycle in which the free count is below the threshold, and low in the cycle after one in which the count is at or above it.
- R8: A consume pulse arriving while the free count is 0 leaves the consume pointer unchanged and sets the underrun flag. The flag stays set until the next base write.
- R9: Data bits [2:0] are ignored on base and free-pointer writes, so both pointers stay 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 base, 1 free pointer, 2 length, 3 threshold) |
| wr_data_i | input | ADDR_W | Write data |
| cons_pulse_i | input | 1 | One-cycle pulse per descriptor used by the receiver |
| free_cnt_o | output | IDX_W | Free descriptors remaining |
| empty_o | output | 1 | No free descriptors |
| fc_o | output | 1 | Flow-control request, registered |
| underrun_o | output | 1 | Sticky consume-while-empty flag |
| cons_ptr_o | output | ADDR_W | Address of the next descriptor the receiver will use |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 4-bit page field and 16-bit descriptor indices. Because the ring length and threshold are run-time registers, short rings of 8 and 5 descriptors put every wrap of the consume pointer and the modulo rollover of the count within a few dozen cycles. The 32-bit address width allows free-pointer writes whose upper page bits differ from the consume pointer, which exercises the page-bit substitution.

// File: rtl/rdt_pkg.sv
`timescale 1ns/1ps
package rdt_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_FREE = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_THR  = 2'd3
  } reg_sel_e;

  // 8-byte descriptors
  localparam int unsigned DESC_SHIFT = 3;
endpackage

// File: rtl/rdt_regs.sv
`timescale 1ns/1ps
module rdt_regs
  import rdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [PAGE_W-1:0] cons_page_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] free_ptr_o,
  output logic [IDX_W-1:0]  len_o,
  output logic [IDX_W-1:0]  thr_o,
  output logic              base_we_o
);
  localparam int unsigned LOW_W = ADDR_W - PAGE_W - DESC_SHIFT;

  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] free_wr;

  assign aligned   = {wr_data_i[ADDR_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
  // page bits come from the consume pointer
  assign free_wr   = {cons_page_i, aligned[DESC_SHIFT +: LOW_W], {DESC_SHIFT{1'b0}}};
  assign base_we_o = wr_en_i && (wr_sel_i == SEL_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o     <= '0;
      free_ptr_o <= '0;
      len_o      <= '0;
      thr_o      <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_BASE: begin
          base_o     <= aligned;
          free_ptr_o <= aligned;
        end
        SEL_FREE: free_ptr_o <= free_wr;
        SEL_LEN:  len_o      <= IDX_W'(wr_data_i);
        default:  thr_o      <= IDX_W'(wr_data_i);
      endcase
    end
  end

  a_r9_free_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_FREE) |=> free_ptr_o[DESC_SHIFT-1:0] == '0);

  a_r6_free_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_FREE) |=>
      free_ptr_o[ADDR_W-1 -: PAGE_W] == $past(cons_page_i));
endmodule

// File: rtl/rdt_cons.sv
`timescale 1ns/1ps
module rdt_cons
  import rdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic              base_we_i,
  input  logic              cons_pulse_i,
  input  logic              cnt_zero_i,
  output logic [IDX_W-1:0]  cons_idx_o,
  output logic [ADDR_W-1:0] cons_ptr_o,
  output logic              underrun_o
);
  logic [IDX_W-1:0] last_idx;

  assign last_idx   = len_i - IDX_W'(1);
  assign cons_ptr_o = base_i + ADDR_W'({cons_idx_o, {DESC_SHIFT{1'b0}}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cons_idx_o <= '0;
      underrun_o <= 1'b0;
    end else if (base_we_i) begin
      cons_idx_o <= '0;
      underrun_o <= 1'b0;
    end else if (cons_pulse_i) begin
      if (cnt_zero_i)                 underrun_o <= 1'b1;
      else if (cons_idx_o == last_idx) cons_idx_o <= '0;
      else                            cons_idx_o <= cons_idx_o + IDX_W'(1);
    end
  end

  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_pulse_i && !cnt_zero_i && !base_we_i && cons_idx_o == last_idx)
      |=> cons_idx_o == '0);

  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_pulse_i && !cnt_zero_i && !base_we_i && cons_idx_o != last_idx)
      |=> cons_idx_o == $past(cons_idx_o) + IDX_W'(1));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_pulse_i && cnt_zero_i && !base_we_i)
      |=> ($stable(cons_idx_o) && underrun_o));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !base_we_i) |=> underrun_o);
endmodule

// File: rtl/rdt_calc.sv
`timescale 1ns/1ps
module rdt_calc
  import rdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] free_ptr_i,
  input  logic [IDX_W-1:0]  cons_idx_i,
  input  logic [IDX_W-1:0]  len_i,
  output logic [IDX_W-1:0]  cnt_o,
  output logic              empty_o
);
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W:0]    wrapped;

  assign off      = free_ptr_i - base_i;
  assign free_idx = IDX_W'(off >> DESC_SHIFT);
  assign wrapped  = {1'b0, free_idx} + {1'b0, len_i} - {1'b0, cons_idx_i};

  always_comb begin
    if (free_idx >= cons_idx_i) cnt_o = free_idx - cons_idx_i;
    else                        cnt_o = IDX_W'(wrapped);
  end

  assign empty_o = (cnt_o == '0);
endmodule

// File: rtl/rdt_fc.sv
`timescale 1ns/1ps
module rdt_fc #(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] cnt_i,
  input  logic [IDX_W-1:0] thr_i,
  output logic             fc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fc_o <= 1'b0;
    else         fc_o <= (cnt_i < thr_i);
  end
endmodule

// File: rtl/rx_free_desc_tracker.sv
`timescale 1ns/1ps
module rx_free_desc_tracker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              cons_pulse_i,
  output logic [IDX_W-1:0]  free_cnt_o,
  output logic              empty_o,
  output logic              fc_o,
  output logic              underrun_o,
  output logic [ADDR_W-1:0] cons_ptr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] free_ptr_q;
  logic [IDX_W-1:0]  len_q;
  logic [IDX_W-1:0]  thr_q;
  logic [IDX_W-1:0]  cons_idx;
  logic              base_we;

  rdt_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .cons_page_i (cons_ptr_o[ADDR_W-1 -: PAGE_W]),
    .base_o      (base_q),
    .free_ptr_o  (free_ptr_q),
    .len_o       (len_q),
    .thr_o       (thr_q),
    .base_we_o   (base_we)
  );

  rdt_cons #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cons (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_i       (base_q),
    .len_i        (len_q),
    .base_we_i    (base_we),
    .cons_pulse_i (cons_pulse_i),
    .cnt_zero_i   (empty_o),
    .cons_idx_o   (cons_idx),
    .cons_ptr_o   (cons_ptr_o),
    .underrun_o   (underrun_o)
  );

  rdt_calc #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_calc (
    .base_i     (base_q),
    .free_ptr_i (free_ptr_q),
    .cons_idx_i (cons_idx),
    .len_i      (len_q),
    .cnt_o      (free_cnt_o),
    .empty_o    (empty_o)
  );

  rdt_fc #(.IDX_W(IDX_W)) u_fc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (free_cnt_o),
    .thr_i  (thr_q),
    .fc_o   (fc_o)
  );

  a_r2_base_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we |=> (empty_o && !underrun_o && cons_ptr_o == free_ptr_q));

  a_r4_equal_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_ptr_q == cons_ptr_o) |-> (empty_o && free_cnt_o == '0));

  a_r7_fc_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fc_o) |-> ($past(free_cnt_o) < $past(thr_q)));

  a_r7_fc_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fc_o) |-> ($past(free_cnt_o) >= $past(thr_q)));
endmodule

// File: tb/rx_free_desc_tracker_test.sv
`timescale 1ns/1ps
module rx_free_desc_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        cons_pulse = 1'b0;
  logic [15:0] free_cnt;
  logic        empty, fc, underrun;
  logic [31:0] cons_ptr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_free_desc_tracker uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .cons_pulse_i(cons_pulse), .free_cnt_o(free_cnt),
    .empty_o(empty), .fc_o(fc), .underrun_o(underrun), .cons_ptr_o(cons_ptr)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    cons_pulse = 1'b1;
    @(negedge clk);
    cons_pulse = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 count", 32'(free_cnt), 0);
    check("R1 empty", 32'(empty), 1);
    check("R1 fc", 32'(fc), 0);
    check("R1 underrun", 32'(underrun), 0);
    check("R1 cons_ptr", cons_ptr, 0);
  endtask

  task automatic t_base();
    wr(2'd2, 32'd8);
    wr(2'd0, 32'h1000_0105);
    check("R9 base aligned", cons_ptr, 32'h1000_0100);
    check("R2 count", 32'(free_cnt), 0);
    check("R2 empty", 32'(empty), 1);
  endtask

  task automatic t_free();
    wr(2'd1, 32'h1000_0128);
    check("R3 count 5", 32'(free_cnt), 5);
    check("R3 not empty", 32'(empty), 0);
    wr(2'd1, 32'hF000_012B);
    check("R6 R9 page and low bits", 32'(free_cnt), 5);
    wr(2'd1, 32'h1000_0100);
    check("R4 equal count", 32'(free_cnt), 0);
    check("R4 equal empty", 32'(empty), 1);
  endtask

  task automatic t_wrap8();
    wr(2'd1, 32'h1000_0138);
    check("R3 count 7", 32'(free_cnt), 7);
    for (int i = 0; i < 7; i++) pulse();
    check("R5 count after 7", 32'(free_cnt), 0);
    check("R5 ptr at last", cons_ptr, 32'h1000_0138);
    wr(2'd1, 32'h1000_0100);
    check("R3 modulo count", 32'(free_cnt), 1);
    pulse();
    check("R5 wrap to base", cons_ptr, 32'h1000_0100);
    check("R5 count after wrap", 32'(free_cnt), 0);
    wr(2'd1, 32'h1000_0118);
    check("R3 count 3", 32'(free_cnt), 3);
  endtask

  task automatic t_fc();
    wr(2'd3, 32'd4);
    check("R7 fc latency", 32'(fc), 0);
    idle();
    check("R7 fc asserted", 32'(fc), 1);
    wr(2'd1, 32'h1000_0120);
    check("R3 count 4", 32'(free_cnt), 4);
    check("R7 fc still high", 32'(fc), 1);
    idle();
    check("R7 fc released at threshold", 32'(fc), 0);
    pulse();
    check("R5 decrement", 32'(free_cnt), 3);
    check("R7 fc pre-edge", 32'(fc), 0);
    idle();
    check("R7 fc reasserted", 32'(fc), 1);
  endtask

  task automatic t_underrun();
    wr(2'd1, 32'h1000_0108);
    check("R4 equal after consume", 32'(empty), 1);
    pulse();
    check("R8 ptr held", cons_ptr, 32'h1000_0108);
    check("R8 flag set", 32'(underrun), 1);
    pulse();
    check("R8 ptr held again", cons_ptr, 32'h1000_0108);
    wr(2'd1, 32'h1000_0118);
    check("R3 count 2", 32'(free_cnt), 2);
    check("R8 sticky", 32'(underrun), 1);
    wr(2'd0, 32'h1000_0100);
    check("R2 underrun cleared", 32'(underrun), 0);
    check("R2 ptr rewound", cons_ptr, 32'h1000_0100);
    check("R2 count cleared", 32'(free_cnt), 0);
  endtask

  task automatic t_wrap5();
    wr(2'd2, 32'd5);
    wr(2'd0, 32'h2000_0000);
    wr(2'd1, 32'h2000_0020);
    check("R3 len5 count 4", 32'(free_cnt), 4);
    for (int i = 0; i < 4; i++) pulse();
    check("R5 len5 at last", cons_ptr, 32'h2000_0020);
    wr(2'd1, 32'h2000_0000);
    check("R3 len5 modulo", 32'(free_cnt), 1);
    pulse();
    check("R5 len5 wrap", cons_ptr, 32'h2000_0000);
    wr(2'd1, 32'h2000_0010);
    check("R3 len5 count 2", 32'(free_cnt), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_base();
    t_free();
    t_wrap8();
    t_fc();
    t_underrun();
    t_wrap5();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule